// File: doc/BRIEF.md
# Carry-Save Vector Dot-Product Unit

This block computes the dot product of two streams of unsigned integers. Each clock it can take one operand pair, multiply it in a carry-save array and fold the product into a running total that is held inside the pipeline. When a vector ends, that total comes out as a single scalar. The multiplier leaves its result as a redundant pseudo-sum and pseudo-carry pair. A separate add stage turns that pair into the true product, and an accumulate stage adds the product to the total. Because the total never leaves the unit, consecutive elements never wait on one another.

Each element carries a mode bit. In single mode the low 32 bits of the two operands are multiplied. In double mode the full 64-bit operands are multiplied modulo 2^64. The unit builds that product from three 32×32 passes that share the same multiplier, so it takes a new pair only once every three clocks. A last flag marks the final element of a vector. If the last flag is raised with valid low, it acts as a closing marker that adds nothing, which is how an empty vector produces a zero result.

Top module: `csa_dot_unit`

## Requirements
- R1: After reset, out_valid and mul_vld are low and in_ready is high.
- R2: One clock after a pass enters the multiplier, mul_vld is high and (mul_psum + mul_pcarry) mod 2^64 equals the unsigned product of that pass's two 32-bit factors. A single-mode element's pass uses in_a[31:0] and in_b[31:0].
- R3: In single mode, out_valid pulses for one clock exactly 4 clocks after the edge that accepts a vector's last element, and out_sum holds the sum of the unsigned products of the low 32-bit halves.
- R4: A double-mode element (in_dbl=1) adds (in_a × in_b) mod 2^64. Its three passes reach the multiplier on consecutive clocks in this order: a_lo×b_lo, a_hi×b_lo, a_lo×b_hi. When it is the last element, the result appears 6 clocks after its accepting edge.
- R5: After a double-mode element is accepted, in_ready is low for the next two clocks. Any input presented while in_ready is low has no effect on any result.
- R6: The first element accepted after a vector closes starts a fresh total. Vectors presented back to back give independent results.
- R7: Raising in_last with in_valid low while in_ready is high closes the current vector and adds nothing. If no element is open, the result is zero. The result appears 4 clocks later.
- R8: The total is 80 bits wide, so sums that exceed 2^64 are reported exactly.
- R9: Single-mode and double-mode elements may be mixed freely within one vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_last | input | 1 | Final element of the vector, or a closing marker when in_valid is low |
| in_dbl | input | 1 | 1: 64×64 product mod 2^64; 0: product of the low 32-bit halves |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_ready | output | 1 | Unit can accept an element or a marker this clock |
| mul_vld | output | 1 | Multiplier output pair is valid |
| mul_psum | output | 64 | Pseudo-sum from the carry-save array |
| mul_pcarry | output | 64 | Pseudo-carry from the carry-save array |
| out_valid | output | 1 | One-clock pulse carrying a finished dot product |
| out_sum | output | 80 | Dot product result |

## Verification
The bench goes after several corner cases.

- **Carry-save array.** All-ones factors force carries through every compressor row. A row that drops a carry or misplaces one by a bit would show a sum/carry pair that no longer adds up to the product.
- **Double-mode cross terms.** The bench checks that the cross terms are weighted by 2^32 and truncated. A wrong shift or a missing wrap would corrupt only double-mode results, so mixed vectors expose it.
- **Hold-off window.** The bench sends junk during the two clocks after a double-mode element. A unit that took that junk would add it to the total.
- **Clearing and closing.** The bench runs back-to-back single-element vectors, empty vectors and vectors closed by a marker. A unit that clears late would carry the old total into the next result, and one that mishandles the marker would report a stale sum instead of zero.
- **Wide totals.** Totals above 2^64 catch an accumulator that was truncated.

// File: rtl/dp_pkg.sv
package dp_pkg;

  // Control that travels alongside each multiplier pass
  typedef struct packed {
    logic       vld;    // pass is live
    logic       first;  // opens a new vector
    logic       last;   // closes the vector
    logic       dbl;    // belongs to a 64x64 element
    logic [1:0] part;   // pass index inside a double element
  } dp_tag_t;

  localparam int unsigned DBL_PASSES = 3;

endpackage

// File: rtl/dp_issue.sv
module dp_issue import dp_pkg::*; #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           in_last,
  input  logic           in_dbl,
  input  logic [2*W-1:0] in_a,
  input  logic [2*W-1:0] in_b,
  output logic           in_ready,
  output logic [W-1:0]   iss_a,
  output logic [W-1:0]   iss_b,
  output dp_tag_t        iss_tag
);

  localparam int unsigned P = 2 * W;

  logic [1:0]   pass_cnt;
  logic [P-1:0] hold_a, hold_b;
  logic         hold_first, hold_last;
  logic         vec_open;
  logic         take_elem, take_mark;

  assign in_ready  = (pass_cnt == 2'd0);
  assign take_elem = in_ready && in_valid;
  assign take_mark = in_ready && !in_valid && in_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pass_cnt   <= 2'd0;
      hold_a     <= '0;
      hold_b     <= '0;
      hold_first <= 1'b0;
      hold_last  <= 1'b0;
      vec_open   <= 1'b0;
      iss_a      <= '0;
      iss_b      <= '0;
      iss_tag    <= '0;
    end else begin
      iss_tag.vld <= 1'b0;
      if (pass_cnt != 2'd0) begin
        // cross terms of a double element, high-by-low first
        iss_a         <= (pass_cnt == 2'd1) ? hold_a[P-1:W] : hold_a[W-1:0];
        iss_b         <= (pass_cnt == 2'd1) ? hold_b[W-1:0] : hold_b[P-1:W];
        iss_tag.vld   <= 1'b1;
        iss_tag.first <= hold_first;
        iss_tag.last  <= hold_last;
        iss_tag.dbl   <= 1'b1;
        iss_tag.part  <= pass_cnt;
        pass_cnt      <= (pass_cnt == 2'(DBL_PASSES - 1)) ? 2'd0 : pass_cnt + 2'd1;
      end else if (take_elem) begin
        iss_a         <= in_a[W-1:0];
        iss_b         <= in_b[W-1:0];
        iss_tag.vld   <= 1'b1;
        iss_tag.first <= !vec_open;
        iss_tag.last  <= in_last;
        iss_tag.dbl   <= in_dbl;
        iss_tag.part  <= 2'd0;
        vec_open      <= !in_last;
        if (in_dbl) begin
          hold_a     <= in_a;
          hold_b     <= in_b;
          hold_first <= !vec_open;
          hold_last  <= in_last;
          pass_cnt   <= 2'd1;
        end
      end else if (take_mark) begin
        // closing marker: a zero pass that only carries the last flag
        iss_a         <= '0;
        iss_b         <= '0;
        iss_tag.vld   <= 1'b1;
        iss_tag.first <= !vec_open;
        iss_tag.last  <= 1'b1;
        iss_tag.dbl   <= 1'b0;
        iss_tag.part  <= 2'd0;
        vec_open      <= 1'b0;
      end
    end
  end

  // R5: a double element blocks the next clock's input
  p_dbl_holdoff_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_dbl) |=> !in_ready);

  // R4: the final cross pass always follows the first cross pass
  p_pass_order_r4: assert property (@(posedge clk) disable iff (rst)
    (iss_tag.vld && iss_tag.part == 2'd2) |-> $past(iss_tag.vld && iss_tag.part == 2'd1));

endmodule

// File: rtl/dp_csa_mul.sv
module dp_csa_mul import dp_pkg::*; #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  dp_tag_t        tag_in,
  output logic [2*W-1:0] psum,
  output logic [2*W-1:0] pcarry,
  output dp_tag_t        tag_out
);

  localparam int unsigned P = 2 * W;

  logic [P-1:0] pp    [W];
  logic [P-1:0] s_row [W];
  logic [P-1:0] c_row [W];

  // one partial product per multiplier bit
  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp[i] = b[i] ? (P'(a) << i) : '0;
  end

  assign s_row[0] = '0;
  assign c_row[0] = '0;
  assign s_row[1] = pp[0];
  assign c_row[1] = pp[1];

  // chain of 3:2 compressor rows, each folding in one more partial product
  for (genvar r = 2; r < W; r++) begin : g_row
    assign s_row[r] = s_row[r-1] ^ c_row[r-1] ^ pp[r];
    assign c_row[r] = ((s_row[r-1] & c_row[r-1]) |
                       (s_row[r-1] & pp[r])      |
                       (c_row[r-1] & pp[r])) << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      psum    <= '0;
      pcarry  <= '0;
      tag_out <= '0;
    end else begin
      psum    <= s_row[W-1];
      pcarry  <= c_row[W-1];
      tag_out <= tag_in;
    end
  end

  logic [P-1:0] ref_prod;
  assign ref_prod = P'(a) * P'(b);

  // R2: redundant pair resolves to the true product of the previous factors
  p_csa_exact_r2: assert property (@(posedge clk) disable iff (rst)
    tag_out.vld |-> (P'(psum + pcarry) == $past(ref_prod)));

endmodule

// File: rtl/dp_resolve.sv
module dp_resolve import dp_pkg::*; #(
  parameter int unsigned P = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [P-1:0] psum,
  input  logic [P-1:0] pcarry,
  input  dp_tag_t      tag_in,
  output logic [P-1:0] prod,
  output dp_tag_t      tag_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prod    <= '0;
      tag_out <= '0;
    end else begin
      prod    <= psum + pcarry;
      tag_out <= tag_in;
    end
  end

endmodule

// File: rtl/dp_accum.sv
module dp_accum import dp_pkg::*; #(
  parameter int unsigned W = 32,
  parameter int unsigned A = 80
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*W-1:0] prod,
  input  dp_tag_t        tag,
  output logic           out_valid,
  output logic [A-1:0]   out_sum
);

  localparam int unsigned P = 2 * W;

  logic [P-1:0] contrib, part_sum, elem;
  logic [A-1:0] total, base;
  logic         fin, done;

  // cross terms land 2^W up; their upper half falls outside the 2W-bit result
  assign contrib = (tag.dbl && tag.part != 2'd0) ? {prod[W-1:0], {W{1'b0}}} : prod;
  assign fin     = !tag.dbl || (tag.part == 2'(DBL_PASSES - 1));
  assign elem    = tag.dbl ? (part_sum + contrib) : contrib;
  assign base    = tag.first ? '0 : total;

  always_ff @(posedge clk) begin
    if (rst) begin
      part_sum  <= '0;
      total     <= '0;
      done      <= 1'b0;
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      done <= 1'b0;
      if (tag.vld && !fin)
        part_sum <= (tag.part == 2'd0) ? contrib : part_sum + contrib;
      if (tag.vld && fin) begin
        total <= base + A'(elem);
        done  <= tag.last;
      end
      out_valid <= done;
      if (done) out_sum <= total;
    end
  end

  // R3: a result only follows a closing pass through this stage
  p_out_after_last_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(tag.vld && fin && tag.last, 2));

  // R4: the closing pass of a double element follows its second pass
  p_dbl_complete_r4: assert property (@(posedge clk) disable iff (rst)
    (tag.vld && tag.dbl && tag.part == 2'd2) |-> $past(tag.vld && tag.dbl && tag.part == 2'd1));

endmodule

// File: rtl/csa_dot_unit.sv
module csa_dot_unit import dp_pkg::*; #(
  parameter int unsigned OPW  = 32,
  parameter int unsigned ACCW = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic              in_dbl,
  input  logic [2*OPW-1:0]  in_a,
  input  logic [2*OPW-1:0]  in_b,
  output logic              in_ready,
  output logic              mul_vld,
  output logic [2*OPW-1:0]  mul_psum,
  output logic [2*OPW-1:0]  mul_pcarry,
  output logic              out_valid,
  output logic [ACCW-1:0]   out_sum
);

  localparam int unsigned PW = 2 * OPW;

  logic [OPW-1:0] iss_a, iss_b;
  dp_tag_t        iss_tag, mul_tag, res_tag;
  logic [PW-1:0]  res_prod;

  dp_issue #(.W(OPW)) u_issue (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_last(in_last), .in_dbl(in_dbl),
    .in_a(in_a), .in_b(in_b), .in_ready(in_ready),
    .iss_a(iss_a), .iss_b(iss_b), .iss_tag(iss_tag)
  );

  dp_csa_mul #(.W(OPW)) u_mul (
    .clk(clk), .rst(rst),
    .a(iss_a), .b(iss_b), .tag_in(iss_tag),
    .psum(mul_psum), .pcarry(mul_pcarry), .tag_out(mul_tag)
  );

  dp_resolve #(.P(PW)) u_res (
    .clk(clk), .rst(rst),
    .psum(mul_psum), .pcarry(mul_pcarry), .tag_in(mul_tag),
    .prod(res_prod), .tag_out(res_tag)
  );

  dp_accum #(.W(OPW), .A(ACCW)) u_acc (
    .clk(clk), .rst(rst),
    .prod(res_prod), .tag(res_tag),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  assign mul_vld = mul_tag.vld;

endmodule

// File: tb/csa_dot_unit_tb.sv
module csa_dot_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_last, in_dbl;
  logic [63:0] in_a, in_b;
  logic        in_ready, mul_vld, out_valid;
  logic [63:0] mul_psum, mul_pcarry;
  logic [79:0] out_sum;

  csa_dot_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last), .in_dbl(in_dbl),
    .in_a(in_a), .in_b(in_b), .in_ready(in_ready), .mul_vld(mul_vld),
    .mul_psum(mul_psum), .mul_pcarry(mul_pcarry), .out_valid(out_valid), .out_sum(out_sum)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int busy = 0;
  bit vec_open = 0;
  logic [79:0] run = '0;
  logic [63:0] exp_mul [int];
  logic [79:0] exp_out [int];
  string       exp_tag [int];

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] m32(input logic [31:0] x, input logic [31:0] y);
    return {32'b0, x} * {32'b0, y};
  endfunction

  // one clock: drive at negedge, model the accept, check after the edge
  task automatic step(input logic v, input logic l, input logic d,
                      input logic [63:0] a, input logic [63:0] b, input string tg);
    int e;
    bit rdy;
    logic [63:0] pe;
    logic [63:0] ms;
    in_valid = v; in_last = l; in_dbl = d; in_a = a; in_b = b;
    #1;
    rdy = (busy == 0);
    chk(in_ready == rdy, "R5 ready", 80'(in_ready), 80'(rdy));
    e = cyc + 1;
    if (!rdy) busy--;
    if (rdy && v) begin
      if (d) begin
        pe = a * b;
        exp_mul[e+1] = m32(a[31:0], b[31:0]);
        exp_mul[e+2] = m32(a[63:32], b[31:0]);
        exp_mul[e+3] = m32(a[31:0], b[63:32]);
        busy = 2;
      end else begin
        pe = m32(a[31:0], b[31:0]);
        exp_mul[e+1] = pe;
      end
      if (!vec_open) run = '0;
      run = run + 80'(pe);
      vec_open = !l;
      if (l) begin
        exp_out[e + (d ? 6 : 4)] = run;
        exp_tag[e + (d ? 6 : 4)] = tg;
      end
    end else if (rdy && l) begin
      exp_mul[e+1] = '0;
      if (!vec_open) run = '0;
      exp_out[e+4] = run;
      exp_tag[e+4] = tg;
      vec_open = 0;
    end
    @(posedge clk);
    cyc = e;
    #2;
    chk(mul_vld == exp_mul.exists(cyc), "R2 mul_vld", 80'(mul_vld), 80'(exp_mul.exists(cyc)));
    if (exp_mul.exists(cyc)) begin
      ms = mul_psum + mul_pcarry;
      chk(ms == exp_mul[cyc], "R2 sum/carry pair", 80'(ms), 80'(exp_mul[cyc]));
      exp_mul.delete(cyc);
    end
    if (exp_out.exists(cyc)) begin
      chk(out_valid === 1'b1, {exp_tag[cyc], " out_valid"}, 80'(out_valid), 80'(1));
      chk(out_sum == exp_out[cyc], {exp_tag[cyc], " out_sum"}, out_sum, exp_out[cyc]);
      exp_out.delete(cyc);
      exp_tag.delete(cyc);
    end else begin
      chk(out_valid === 1'b0, "R3 no spurious result", 80'(out_valid), 80'(0));
    end
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, "R3");
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 0; in_last = 0; in_dbl = 0; in_a = '0; in_b = '0;
    repeat (3) @(posedge clk);
    #4 rst = 1'b0;
    // R1 reset state
    chk(out_valid === 1'b0, "R1 out_valid", 80'(out_valid), 80'(0));
    chk(mul_vld === 1'b0, "R1 mul_vld", 80'(mul_vld), 80'(0));
    chk(in_ready === 1'b1, "R1 in_ready", 80'(in_ready), 80'(1));

    // R2/R3: single-mode vector of four, high halves ignored
    step(1, 0, 0, 64'hDEAD_0000_0000_0003, 64'h0000_0007, "R3");
    step(1, 0, 0, 64'h0000_1234, 64'hBEEF_0000_0000_5678, "R3");
    step(1, 0, 0, 64'h8000_0001, 64'hFFFF_FFFF, "R3");
    step(1, 1, 0, 64'h0000_0000, 64'h1234_5678, "R3");
    idle(6);

    // R8: all-ones single products push the total past 2^64
    for (int i = 0; i < 5; i++)
      step(1, i == 4, 0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R8");
    idle(6);

    // R4: double-mode vector
    step(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
    idle(2);
    step(1, 1, 1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, "R4");
    idle(2);
    idle(6);

    // R5: junk during the hold-off window must be ignored
    step(1, 0, 1, 64'h0000_0002_0000_0003, 64'h0000_0005_0000_0007, "R5");
    step(1, 1, 0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R5");
    step(0, 1, 1, 64'h1, 64'h1, "R5");
    step(1, 1, 0, 64'h0000_0010, 64'h0000_0011, "R5");
    idle(8);

    // R9: modes mixed inside one vector, back-to-back with next
    step(1, 0, 0, 64'h0000_0100, 64'h0000_0200, "R9");
    step(1, 0, 1, 64'h7777_0000_1111_2222, 64'h0000_3333_4444_5555, "R9");
    step(0, 0, 0, '0, '0, "R9");
    step(0, 0, 0, '0, '0, "R9");
    step(1, 1, 0, 64'hABCD_0000, 64'h0003_0000, "R9");

    // R6: single-element vectors back to back
    step(1, 1, 0, 64'd9, 64'd11, "R6");
    step(1, 1, 0, 64'd13, 64'd2, "R6");
    step(1, 1, 1, 64'h1_0000_0001, 64'h2_0000_0003, "R6");
    idle(2);
    step(1, 1, 0, 64'd5, 64'd5, "R6");
    idle(6);

    // R7: empty vector, then a marker closing an open vector
    step(0, 1, 0, '0, '0, "R7");
    step(0, 1, 0, '0, '0, "R7");
    step(1, 0, 0, 64'd40, 64'd3, "R7");
    step(1, 0, 0, 64'd6, 64'd7, "R7");
    step(0, 1, 0, '0, '0, "R7");
    idle(6);

    // random mixed traffic against the model
    for (int i = 0; i < 200; i++) begin
      logic [63:0] ra, rb;
      logic dv, lv, vv;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      dv = ($urandom % 3) == 0;
      lv = ($urandom % 5) == 0;
      vv = ($urandom % 6) != 0;
      step(vv, lv, dv, ra, rb, "R9");
    end
    idle(10);

    chk(exp_out.num() == 0, "R3 results all seen", 80'(exp_out.num()), 80'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule